// File: doc/BRIEF.md
# AES Single-Round Datapath Unit

This unit carries out exactly one AES round, or one helper step, on a 128-bit state per accepted request. A 3-bit operation code picks one of these functions:

- a full encrypt round;
- the final encrypt round;
- a full decrypt round;
- the final decrypt round;
- a standalone inverse column mix, used to convert round keys for decryption;
- a key-expansion assist step that takes an 8-bit round constant.

A controller outside the unit supplies the round keys and chains the rounds. The unit does not hold a key schedule and does not sequence rounds.

Byte 0 is the least significant byte of each 128-bit vector. The state is column-major: bytes 4c to 4c+3 form column c, and byte 4c+r sits in row r. The decrypt round applies the inverse column mix before the key XOR. A full decryption therefore uses middle-round keys that were first passed through the inverse-mix operation.

The input side uses a valid/ready handshake. The result is registered and appears one cycle after acceptance. It stays held while the output side is stalled.

Top module: `aesr_round_unit`

## Requirements
- R1: Op code 0 (encrypt round) returns MixColumns(ShiftRows(SubBytes(state))) XOR key. Ten chained rounds with the expanded keys of the standard AES-128 test key give the standard ciphertext.
- R2: Op code 1 (final encrypt round) returns ShiftRows(SubBytes(state)) XOR key, with no column mixing.
- R3: Op code 2 (decrypt round) returns InvMixColumns(InvSubBytes(InvShiftRows(state))) XOR key. Inverse mixing comes before the key XOR, so decrypting with inverse-mixed middle keys recovers the plaintext.
- R4: Op code 3 (final decrypt round) returns InvSubBytes(InvShiftRows(state)) XOR key, with no column mixing.
- R5: Op code 4 returns InvMixColumns(state). The key input has no effect on the result.
- R6: Op code 5 (key assist) substitutes all 16 bytes, giving words S0..S3, where word w is bytes 4w to 4w+3. The result words, from word 0 up, are S1, ror8(S1)^C, S3 and ror8(S3)^C. Here ror8 moves byte 1 of the word into byte 0, and C is the 8-bit constant zero-extended to 32 bits. The key input has no effect.
- R7: Op codes 6 and 7 return an all-zero result.
- R8: Byte 0 is bits 7:0, and the state is column-major with byte 4c+r at row r, column c. Row shifting moves bytes only between columns, within a row.
- R9: A request accepted at a clock edge (in_valid and in_ready both high) is presented on out_valid/out_data after that edge. out_valid falls after an edge at which the output was taken and no new request was accepted.
- R10: While out_valid is high and out_ready is low, out_data and out_valid hold and in_ready is low. in_ready is high whenever out_valid is low.
- R11: During reset, out_valid is low, out_data is zero and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request this cycle |
| in_op | input | 3 | Operation code (0 to 7) |
| in_state | input | 128 | State or operand, byte 0 in bits 7:0 |
| in_key | input | 128 | Round key |
| in_rcon | input | 8 | Round constant for key assist |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 128 | Registered result |

## Verification
A wrong S-box entry, row offset or mixing coefficient shows up in out_data one cycle after the request is accepted. Because every byte is diffused, one bad byte corrupts the whole ten-round chain, and the chained ciphertext and recovered plaintext expose it at the end of each run. A fault in the output register or the handshake shows at the ports within one cycle: out_valid drops out of step, out_data changes during a stall, or in_ready is high while a result is held. The key-assist word relation and the zero result for the reserved codes are checked on every transfer.

// File: rtl/aesr_pkg.sv
package aesr_pkg;

   typedef enum logic [2:0] {
      OP_ENC        = 3'd0,
      OP_ENC_LAST   = 3'd1,
      OP_DEC        = 3'd2,
      OP_DEC_LAST   = 3'd3,
      OP_INV_MIX    = 3'd4,
      OP_KEY_ASSIST = 3'd5
   } aesr_op_e;

   // GF(2^8) doubling modulo x^8+x^4+x^3+x+1
   function automatic logic [7:0] gf_dbl(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] p;
      acc = 8'h00;
      p   = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ p;
         p = gf_dbl(p);
      end
      return acc;
   endfunction

   // multiplicative inverse as a^254 (zero maps to zero)
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] r;
      logic [7:0] p;
      logic [7:0] e;
      r = 8'h01;
      p = a;
      e = 8'd254;
      for (int i = 0; i < 8; i++) begin
         if (e[i]) r = gf_mul(r, p);
         p = gf_mul(p, p);
      end
      return r;
   endfunction

   function automatic logic [7:0] rotl8(input logic [7:0] b, input int k);
      return (b << k) | (b >> (8 - k));
   endfunction

   function automatic logic [7:0] aff_fwd(input logic [7:0] b);
      return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
   endfunction

   function automatic logic [7:0] aff_inv(input logic [7:0] b);
      return rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
   endfunction

endpackage

// File: rtl/aesr_sbox.sv
module aesr_sbox #(
   parameter bit INVERSE = 1'b0
) (
   input  logic [7:0] a_i,
   output logic [7:0] y_o
);
   generate
      if (INVERSE) begin : g_inv
         assign y_o = aesr_pkg::gf_inv(aesr_pkg::aff_inv(a_i));
      end else begin : g_fwd
         assign y_o = aesr_pkg::aff_fwd(aesr_pkg::gf_inv(a_i));
      end
   endgenerate
endmodule

// File: rtl/aesr_mixcol.sv
module aesr_mixcol #(
   parameter bit INVERSE = 1'b0
) (
   input  logic [31:0] col_i,
   output logic [31:0] col_o
);
   localparam int ROWS = 4;

   logic [ROWS-1:0][7:0] a;
   logic [ROWS-1:0][7:0] b;

   assign a     = col_i;
   assign col_o = b;

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         if (INVERSE) begin : g_inv
            assign b[r] = aesr_pkg::gf_mul(a[r], 8'h0e)
                        ^ aesr_pkg::gf_mul(a[(r+1)%ROWS], 8'h0b)
                        ^ aesr_pkg::gf_mul(a[(r+2)%ROWS], 8'h0d)
                        ^ aesr_pkg::gf_mul(a[(r+3)%ROWS], 8'h09);
         end else begin : g_fwd
            assign b[r] = aesr_pkg::gf_dbl(a[r])
                        ^ aesr_pkg::gf_dbl(a[(r+1)%ROWS]) ^ a[(r+1)%ROWS]
                        ^ a[(r+2)%ROWS] ^ a[(r+3)%ROWS];
         end
      end
   endgenerate
endmodule

// File: rtl/aesr_round_unit.sv
module aesr_round_unit
   import aesr_pkg::*;
#(
   parameter int ROWS     = 4,
   parameter int NUM_COLS = 4,
   parameter int RCON_W   = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic [2:0]                  in_op,
   input  logic [8*ROWS*NUM_COLS-1:0]  in_state,
   input  logic [8*ROWS*NUM_COLS-1:0]  in_key,
   input  logic [RCON_W-1:0]           in_rcon,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic [8*ROWS*NUM_COLS-1:0]  out_data
);
   localparam int NB     = ROWS * NUM_COLS;
   localparam int DW     = 8 * NB;
   localparam int WORD_W = 8 * ROWS;

   generate
      if (ROWS != 4 || NUM_COLS != 4) begin : g_bad_shape
         $error("aesr_round_unit: state must be 4 rows by 4 columns");
      end
      if (RCON_W < 1 || RCON_W > WORD_W) begin : g_bad_rcon
         $error("aesr_round_unit: RCON_W must lie in 1..WORD_W");
      end
   endgenerate

   logic [NB-1:0][7:0] st_b, sb_b, isb_b, sh_b, ish_b;
   logic [NB-1:0][7:0] mix_b, imx_in_b, imx_b, ka_b;
   logic [DW-1:0]      res;
   logic               take;

   assign st_b = in_state;

   // byte substitution on the raw state; row shift applied afterwards
   generate
      for (genvar b = 0; b < NB; b++) begin : g_byte
         aesr_sbox #(.INVERSE(1'b0)) u_fwd (.a_i(st_b[b]), .y_o(sb_b[b]));
         aesr_sbox #(.INVERSE(1'b1)) u_inv (.a_i(st_b[b]), .y_o(isb_b[b]));
      end
   endgenerate

   // row r rotates left by r columns (forward) or right by r (inverse)
   generate
      for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
         for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign sh_b[r + ROWS*c]  = sb_b[r + ROWS*((c + r) % NUM_COLS)];
            assign ish_b[r + ROWS*c] = isb_b[r + ROWS*((c + NUM_COLS - r) % NUM_COLS)];
         end
      end
   endgenerate

   assign imx_in_b = (in_op == OP_INV_MIX) ? st_b : ish_b;

   generate
      for (genvar c = 0; c < NUM_COLS; c++) begin : g_mix
         aesr_mixcol #(.INVERSE(1'b0)) u_mf (
            .col_i(sh_b[ROWS*c +: ROWS]),
            .col_o(mix_b[ROWS*c +: ROWS])
         );
         aesr_mixcol #(.INVERSE(1'b1)) u_mi (
            .col_i(imx_in_b[ROWS*c +: ROWS]),
            .col_o(imx_b[ROWS*c +: ROWS])
         );
      end
   endgenerate

   // key-expansion assist on substituted words 1 and 3
   logic [WORD_W-1:0] ka_w1, ka_w3, rc_w;
   assign ka_w1 = sb_b[ROWS*1 +: ROWS];
   assign ka_w3 = sb_b[ROWS*3 +: ROWS];
   assign rc_w  = WORD_W'(in_rcon);
   assign ka_b  = {{ka_w3[7:0], ka_w3[WORD_W-1:8]} ^ rc_w, ka_w3,
                   {ka_w1[7:0], ka_w1[WORD_W-1:8]} ^ rc_w, ka_w1};

   always_comb begin
      case (in_op)
         OP_ENC:        res = mix_b ^ in_key;
         OP_ENC_LAST:   res = sh_b  ^ in_key;
         OP_DEC:        res = imx_b ^ in_key;
         OP_DEC_LAST:   res = ish_b ^ in_key;
         OP_INV_MIX:    res = imx_b;
         OP_KEY_ASSIST: res = ka_b;
         default:       res = '0;
      endcase
   end

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (take) begin
         out_valid <= 1'b1;
         out_data  <= res;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/aesr_round_chk.sv
module aesr_round_chk #(
   parameter int DW     = 128,
   parameter int RCON_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [2:0]        in_op,
   input logic [RCON_W-1:0] in_rcon,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DW-1:0]     out_data
);
   logic acc;
   assign acc = in_valid && in_ready;

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   p_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> out_valid);

   p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !acc |=> !out_valid);

   p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc && in_op[2:1] == 2'b11 |=> out_data == '0);

   p_assist_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc && in_op == 3'd5 |=>
         out_data[63:32] == ({out_data[7:0], out_data[31:8]} ^ 32'($past(in_rcon))));
endmodule

bind aesr_round_unit aesr_round_chk #(.DW(DW), .RCON_W(RCON_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_op(in_op), .in_rcon(in_rcon), .out_valid(out_valid),
   .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_aesr_round_unit.sv
module sim_aesr_round_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [2:0]   in_op = 3'd0;
   logic [127:0] in_state = '0;
   logic [127:0] in_key = '0;
   logic [7:0]   in_rcon = 8'd0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [127:0] out_data;

   always #4 clk = ~clk;

   aesr_round_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_state(in_state), .in_key(in_key), .in_rcon(in_rcon),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   int n_tests = 0;
   int n_fail  = 0;
   logic [127:0] exp_q[$];
   string        tag_q[$];
   logic [127:0] last_out = '0;
   logic [7:0]   sbt[256];
   logic [7:0]   isbt[256];
   logic [127:0] rk[11];

   task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] xt(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] s = 8'h00;
      for (int i = 7; i >= 0; i--) begin
         s = xt(s);
         if (b[i]) s = s ^ a;
      end
      return s;
   endfunction

   // S-box tables from exp/log over generator 3
   task automatic build_tables();
      logic [7:0] ex[256];
      int lg[256];
      logic [7:0] v = 8'h01;
      for (int i = 0; i < 255; i++) begin
         ex[i] = v;
         lg[v] = i;
         v = v ^ xt(v);
      end
      for (int x = 0; x < 256; x++) begin
         logic [7:0] q, s;
         q = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
         s = 8'h63;
         for (int i = 0; i < 8; i++)
            s[i] = s[i] ^ q[i] ^ q[(i+4)%8] ^ q[(i+5)%8] ^ q[(i+6)%8] ^ q[(i+7)%8];
         sbt[x] = s;
      end
      for (int x = 0; x < 256; x++) isbt[sbt[x]] = 8'(x);
   endtask

   function automatic logic [127:0] be(input logic [127:0] v);
      logic [127:0] o;
      for (int i = 0; i < 16; i++) o[8*i +: 8] = v[8*(15-i) +: 8];
      return o;
   endfunction

   function automatic logic [127:0] r_sub(input logic [127:0] s, input bit inv);
      logic [127:0] o;
      for (int i = 0; i < 16; i++) o[8*i +: 8] = inv ? isbt[s[8*i +: 8]] : sbt[s[8*i +: 8]];
      return o;
   endfunction

   function automatic logic [127:0] r_shift(input logic [127:0] s, input bit inv);
      logic [127:0] o;
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++)
            o[8*(r+4*c) +: 8] = s[8*(r + 4*((c + (inv ? 4 - r : r)) % 4)) +: 8];
      return o;
   endfunction

   function automatic logic [127:0] r_mix(input logic [127:0] s, input bit inv);
      logic [127:0] o;
      logic [7:0] k0, k1, k2, k3;
      k0 = inv ? 8'h0e : 8'h02; k1 = inv ? 8'h0b : 8'h03;
      k2 = inv ? 8'h0d : 8'h01; k3 = inv ? 8'h09 : 8'h01;
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++)
            o[8*(r+4*c) +: 8] = gm(s[8*(4*c + r) +: 8], k0) ^ gm(s[8*(4*c + (r+1)%4) +: 8], k1)
                              ^ gm(s[8*(4*c + (r+2)%4) +: 8], k2) ^ gm(s[8*(4*c + (r+3)%4) +: 8], k3);
      return o;
   endfunction

   function automatic logic [127:0] r_round(input logic [2:0] op, input logic [127:0] s,
                                            input logic [127:0] k, input logic [7:0] rc);
      logic [127:0] t;
      logic [31:0] w1, w3;
      case (op)
         3'd0: return r_mix(r_shift(r_sub(s, 0), 0), 0) ^ k;
         3'd1: return r_shift(r_sub(s, 0), 0) ^ k;
         3'd2: return r_mix(r_sub(r_shift(s, 1), 1), 1) ^ k;
         3'd3: return r_sub(r_shift(s, 1), 1) ^ k;
         3'd4: return r_mix(s, 1);
         3'd5: begin
            t = r_sub(s, 0);
            w1 = t[63:32]; w3 = t[127:96];
            return {{w3[7:0], w3[31:8]} ^ {24'd0, rc}, w3, {w1[7:0], w1[31:8]} ^ {24'd0, rc}, w1};
         end
         default: return '0;
      endcase
   endfunction

   task automatic expand_key(input logic [127:0] key);
      logic [31:0] w[44];
      logic [7:0] rc = 8'h01;
      for (int i = 0; i < 4; i++) w[i] = key[32*i +: 32];
      for (int i = 4; i < 44; i++) begin
         logic [31:0] t;
         t = w[i-1];
         if (i % 4 == 0) begin
            t = {t[7:0], t[31:8]};
            t = {sbt[t[31:24]], sbt[t[23:16]], sbt[t[15:8]], sbt[t[7:0]]} ^ {24'd0, rc};
            rc = xt(rc);
         end
         w[i] = w[i-4] ^ t;
      end
      for (int r = 0; r < 11; r++) rk[r] = {w[4*r+3], w[4*r+2], w[4*r+1], w[4*r]};
   endtask

   task automatic send(input logic [2:0] op, input logic [127:0] s, input logic [127:0] k,
                       input logic [7:0] rc, input string tag);
      bit acc = 1'b0;
      logic [127:0] e;
      e = r_round(op, s, k, rc);
      while (!acc) begin
         @(negedge clk);
         in_valid = 1'b1; in_op = op; in_state = s; in_key = k; in_rcon = rc;
         #1 acc = in_ready;
         @(posedge clk);
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9 unexpected result", out_data, '0);
            end else begin
               logic [127:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(out_data === e, t, out_data, e);
            end
            last_out = out_data;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 128'd0, 128'd1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [127:0] key, pt, ct, s, x, d;
      build_tables();
      key = be(128'h000102030405060708090a0b0c0d0e0f);
      pt  = be(128'h00112233445566778899aabbccddeeff);
      ct  = be(128'h69c4e0d86a7b0430d8cdb78070b4c55a);
      expand_key(key);

      repeat (3) @(negedge clk);
      #3;
      chk(out_valid == 1'b0 && in_ready == 1'b1 && out_data == '0, "R11 reset state",
          {126'd0, out_valid, in_ready}, 128'd1);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 R8: ten chained encrypt rounds against the known answer
      s = pt ^ rk[0];
      for (int r = 1; r < 10; r++) begin
         send(3'd0, s, rk[r], 8'd0, "R1 encrypt round");
         s = r_round(3'd0, s, rk[r], 8'd0);
      end
      send(3'd1, s, rk[10], 8'd0, "R2 final encrypt round");
      idle();
      drain();
      chk(last_out === ct, "R1 R8 chained ciphertext", last_out, ct);

      // R5: convert middle keys on the unit itself
      for (int r = 1; r < 10; r++) send(3'd4, rk[r], rnd128(), 8'd0, "R5 inverse mix of key");
      idle();
      drain();

      // R3 R4: decrypt with pre-mixed middle keys
      s = ct ^ rk[10];
      for (int r = 9; r >= 1; r--) begin
         send(3'd2, s, r_mix(rk[r], 1), 8'd0, "R3 decrypt round");
         s = r_round(3'd2, s, r_mix(rk[r], 1), 8'd0);
      end
      send(3'd3, s, rk[0], 8'd0, "R4 final decrypt round");
      idle();
      drain();
      chk(last_out === pt, "R3 R4 recovered plaintext", last_out, pt);

      // every op code with random operands, back to back
      for (int op = 0; op < 8; op++)
         for (int n = 0; n < 6; n++) begin
            string t;
            case (op)
               0: t = "R1 random"; 1: t = "R2 random"; 2: t = "R3 random"; 3: t = "R4 random";
               4: t = "R5 random"; 5: t = "R6 random"; default: t = "R7 reserved op";
            endcase
            send(3'(op), rnd128(), rnd128(), 8'($urandom), t);
         end
      idle();
      drain();

      // R5 R6: key has no effect on the result
      x = rnd128();
      send(3'd4, x, '0, 8'd0, "R5 key zero");
      send(3'd4, x, '1, 8'd0, "R5 key ones");
      send(3'd5, x, '0, 8'h36, "R6 key zero");
      send(3'd5, x, '1, 8'h36, "R6 key ones");
      send(3'd5, rk[10], rnd128(), 8'h80, "R6 rcon top bit");
      send(3'd5, x, rnd128(), 8'h00, "R6 rcon zero");
      idle();
      drain();

      // R9 R10: stall, hold and drain
      @(negedge clk);
      out_ready = 1'b0;
      x = rnd128();
      send(3'd0, x, rnd128(), 8'd0, "R10 result after stall");
      idle();
      #3;
      chk(out_valid == 1'b1, "R9 valid one cycle after accept", {127'd0, out_valid}, 128'd1);
      chk(in_ready == 1'b0, "R10 ready low while stalled", {127'd0, in_ready}, 128'd0);
      d = out_data;
      repeat (3) @(negedge clk);
      #3;
      chk(out_valid == 1'b1 && out_data == d, "R10 result held", out_data, d);
      @(negedge clk);
      out_ready = 1'b1;
      @(negedge clk);
      #3;
      chk(out_valid == 1'b0, "R9 valid falls after drain", {127'd0, out_valid}, 128'd0);
      chk(in_ready == 1'b1, "R10 ready high when empty", {127'd0, in_ready}, 128'd1);

      drain();
      chk(exp_q.size() == 0, "R9 no result missing", 128'(exp_q.size()), 128'd0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule